// File: doc/BRIEF.md
# Oversampled Serial Bit Timing Recovery

This block recovers bit timing from a full-speed serial line pair. It samples the line with a clock at four times the bit rate, for example a 48 MHz clock obtained by multiplying a 12 MHz reference by four, for a 12 Mbit/s stream. Both raw lines first pass through a two-flop synchronizer. The block then watches the synchronized pair for any change and keeps a free-running phase counter over the four samples of each bit. The recovered bit is taken near the centre of the bit, two samples after the sample that saw the transition.

The phase is checked again at every transition, so the block follows jitter and slow drift within a packet rather than relying on a fixed divide. Each time a transition arrives off schedule, the bit period in progress stretches or shrinks by exactly one sample. Only one such correction is allowed before the next capture. Each captured bit leaves the block with a one-cycle valid strobe and a two-bit line-state code. End-of-packet logic downstream uses that code to tell a single-ended zero apart from data. A sample-enable divider parameter slows the sampling rate for slower links; its default of one samples on every clock.

Top module: `oversample_bit_recovery`

## Requirements
- R1: While reset is high, `bit_valid` is 0, `bit_out` is 0 and `line_state` is 2'b00.
- R2: When the line pair changes before rising edge E0, and the phase was on schedule or one sample off, the new value appears with `bit_valid` high after the fifth rising edge (E4). E0 is counted as the first.
- R3: While the line stays constant, a strobe is produced every four sample ticks, each carrying the unchanged line value.
- R4: `bit_valid` is never high for two consecutive clock cycles.
- R5: A transition arriving one sample early makes the gap between the strobe before it and the strobe after it three ticks.
- R6: A transition arriving one sample late makes that gap five ticks.
- R7: A transition arriving two samples late moves the phase by one sample only, so its strobe comes after four rising edges instead of five. No bit is dropped or duplicated in the stream around it.
- R8: After a correction, further transitions before the next capture leave the phase unchanged. A one-sample glitch right after a late transition therefore gives a strobe five ticks after the previous one, not six.
- R9: `line_state` is the synchronized pair {D+, D-} taken at the capture: 2'b10 idle/J, 2'b01 K, 2'b00 single-ended zero, 2'b11 both high. `bit_out` is the D+ value taken at the same sample.
- R10: `bit_out` and `line_state` change only in the cycle where `bit_valid` is high.
- R11: The spacing between consecutive strobes is always between three and five sample ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock (four times the bit rate) |
| rst | input | 1 | Synchronous active-high reset |
| dp_raw | input | 1 | Asynchronous positive data line |
| dm_raw | input | 1 | Asynchronous negative data line |
| bit_out | output | 1 | Recovered bit (D+ value at the capture sample) |
| bit_valid | output | 1 | One-cycle strobe marking a recovered bit |
| line_state | output | 2 | Line-state code {D+, D-} taken with the bit |

## Verification
The bench sweeps the length of one bit in an alternating stream over three, four, five and six samples. A recovery that snapped fully to every edge would produce a two-cycle jump and the wrong strobe time in the six-sample case. A recovery that never re-phased would drop or repeat a bit, which the per-window strobe count reveals. A one-sample glitch placed right after a late edge targets the single-correction rule: without the guard flag the strobe lands one cycle later. Single-ended-zero runs and idle stretches check that the line-state code separates SE0 from K and that the free-running counter keeps a four-tick cadence when there are no edges.

// File: rtl/obr_pkg.sv
package obr_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_K   = 2'b01,
        LS_J   = 2'b10,
        LS_SE1 = 2'b11
    } line_state_t;

    typedef struct packed {
        logic dp;
        logic dm;
    } line_sample_t;

    typedef struct packed {
        logic        data;
        line_state_t state;
    } rec_bit_t;

    function automatic line_state_t classify(input line_sample_t s);
        return line_state_t'({s.dp, s.dm});
    endfunction

    function automatic int center_of(input int ovs);
        return ovs / 2;
    endfunction

endpackage

// File: rtl/obr_sync.sv
module obr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/obr_tick.sv
module obr_tick #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/obr_edge.sv
module obr_edge
    import obr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  line_sample_t smp,
    output logic         edge_det
);
    line_sample_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else if (tick) begin
            prev_q <= smp;
        end
    end

    assign edge_det = tick && (smp != prev_q);
endmodule

// File: rtl/obr_phase.sv
module obr_phase
    import obr_pkg::*;
#(
    parameter int OVS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic edge_det,
    output logic capture
);
    localparam int PW  = $clog2(OVS);
    localparam int CTR = center_of(OVS);
    localparam logic [PW-1:0] LAST = PW'(OVS - 1);
    localparam logic [PW-1:0] CTRV = PW'(CTR);

    logic [PW-1:0] ph_q;
    logic [PW-1:0] cur;
    logic          used_q;
    logic          adjust;

    always_comb begin
        cur    = ph_q;
        adjust = 1'b0;
        if (edge_det && (ph_q != '0) && !used_q) begin
            adjust = 1'b1;
            if (ph_q == LAST) begin
                cur = '0;
            end else begin
                cur = ph_q - 1'b1;
            end
        end
    end

    assign capture = tick && (cur == CTRV);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            used_q <= 1'b0;
        end else if (tick) begin
            ph_q   <= (cur == LAST) ? '0 : cur + 1'b1;
            used_q <= capture ? 1'b0 : (used_q | adjust);
        end
    end
endmodule

// File: rtl/oversample_bit_recovery.sv
module oversample_bit_recovery
    import obr_pkg::*;
#(
    parameter int OVS         = 4,
    parameter int TICK_DIV    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dp_raw,
    input  logic       dm_raw,
    output logic       bit_out,
    output logic       bit_valid,
    output logic [1:0] line_state
);
    logic [1:0]   sync_q;
    line_sample_t smp;
    logic         tick;
    logic         edge_det;
    logic         capture;
    rec_bit_t     out_q;
    logic         valid_q;

    obr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({dp_raw, dm_raw}),
        .q   (sync_q)
    );

    assign smp = line_sample_t'(sync_q);

    obr_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    obr_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .smp      (smp),
        .edge_det (edge_det)
    );

    obr_phase #(.OVS(OVS)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .edge_det (edge_det),
        .capture  (capture)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '{data: 1'b0, state: LS_SE0};
            valid_q <= 1'b0;
        end else begin
            valid_q <= capture;
            if (capture) begin
                out_q <= '{data: smp.dp, state: classify(smp)};
            end
        end
    end

    assign bit_out    = out_q.data;
    assign line_state = out_q.state;
    assign bit_valid  = valid_q;
endmodule

// File: rtl/obr_checker.sv
module obr_checker #(
    parameter int OVS      = 4,
    parameter int TICK_DIV = 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    bit_valid,
    input logic                    bit_out,
    input logic [1:0]              line_state,
    input logic                    tick,
    input logic                    edge_det,
    input logic [$clog2(OVS)-1:0]  ph,
    input logic                    used
);
    localparam logic [15:0] GAP_MIN = 16'(TICK_DIV * (OVS - 1));
    localparam logic [15:0] GAP_MAX = 16'(TICK_DIV * (OVS + 1));
    localparam logic [$clog2(OVS)-1:0] PH_HI = $clog2(OVS)'(OVS - 2);

    logic [15:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (bit_valid) begin
            gap_q  <= 16'd1;
            seen_q <= 1'b1;
        end else if (gap_q != 16'hFFFF) begin
            gap_q <= gap_q + 16'd1;
        end
    end

    assert_gap_window_R11: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && seen_q) |-> (gap_q >= GAP_MIN && gap_q <= GAP_MAX))
        else $error("strobe spacing out of window");

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid)
        else $error("strobe longer than one cycle");

    assert_hold_between_R10: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |-> ($stable(bit_out) && $stable(line_state)))
        else $error("outputs moved without strobe");

    assert_realign_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && edge_det && !used) |=> (ph >= 1 && ph <= PH_HI))
        else $error("phase not re-centred after transition");
endmodule

bind oversample_bit_recovery obr_checker #(.OVS(OVS), .TICK_DIV(TICK_DIV)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_valid  (bit_valid),
    .bit_out    (bit_out),
    .line_state (line_state),
    .tick       (tick),
    .edge_det   (edge_det),
    .ph         (u_phase.ph_q),
    .used       (u_phase.used_q)
);

// File: tb/oversample_bit_recovery_bench.sv
`timescale 1ns/1ps
module oversample_bit_recovery_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dp_raw = 1'b1;
    logic       dm_raw = 1'b0;
    logic       bit_out;
    logic       bit_valid;
    logic [1:0] line_state;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    int         rec_st [2048];
    logic       rec_v  [2048];
    logic [1:0] rec_ls [2048];
    int         nrec     = 0;
    int         pulse_err = 0;
    int         hold_err  = 0;
    int         gap_err   = 0;
    logic       prev_v    = 1'b0;
    logic       last_b    = 1'b0;
    logic [1:0] last_ls   = 2'b00;

    oversample_bit_recovery u_oversample_bit_recovery (
        .clk        (clk),
        .rst        (rst),
        .dp_raw     (dp_raw),
        .dm_raw     (dm_raw),
        .bit_out    (bit_out),
        .bit_valid  (bit_valid),
        .line_state (line_state)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (bit_valid) begin
                if (prev_v) pulse_err++;
                if (nrec > 0) begin
                    if ((cyc - rec_st[nrec-1]) < 3 || (cyc - rec_st[nrec-1]) > 5) gap_err++;
                end
                if (nrec < 2048) begin
                    rec_st[nrec] = cyc;
                    rec_v[nrec]  = bit_out;
                    rec_ls[nrec] = line_state;
                    nrec++;
                end
                last_b  = bit_out;
                last_ls = line_state;
            end else if (bit_out !== last_b || line_state !== last_ls) begin
                hold_err++;
            end
        end
        prev_v = bit_valid;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int find_rec(input int st);
        for (int i = 0; i < nrec; i++) begin
            if (rec_st[i] == st) return i;
        end
        return -1;
    endfunction

    function automatic int count_in(input int a, input int b);
        int c = 0;
        for (int i = 0; i < nrec; i++) begin
            if (rec_st[i] >= a && rec_st[i] <= b) c++;
        end
        return c;
    endfunction

    task automatic expect_bit(input int st, input logic v, input logic [1:0] ls,
                              input string req);
        int idx = find_rec(st);
        int act = (idx < 0) ? -1 : int'({rec_v[idx], rec_ls[idx]});
        chk(idx >= 0 && rec_v[idx] == v && rec_ls[idx] == ls, req,
            $sformatf("strobe at cycle %0d {bit,state}", st), act, int'({v, ls}));
    endtask

    task automatic expect_none(input int st, input string req);
        int idx = find_rec(st);
        chk(idx < 0, req, $sformatf("no strobe at cycle %0d (index)", st), idx, -1);
    endtask

    task automatic put(input logic v, input int n, output int st);
        @(negedge clk);
        st = cyc;
        dp_raw = v;
        dm_raw = ~v;
        if (n > 1) repeat (n - 1) @(negedge clk);
    endtask

    task automatic put_se0(input int n, output int st);
        @(negedge clk);
        st = cyc;
        dp_raw = 1'b0;
        dm_raw = 1'b0;
        if (n > 1) repeat (n - 1) @(negedge clk);
    endtask

    task automatic summary();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
            summary();
        end
    end

    initial begin
        int s0, s1, s2, s3, s4, s5, s6, si, tmp;
        int g0, z0, z1, e4;
        string tag;

        repeat (4) @(negedge clk);
        // R1: reset values
        chk(bit_valid == 1'b0, "R1", "bit_valid in reset", int'(bit_valid), 0);
        chk(bit_out == 1'b0, "R1", "bit_out in reset", int'(bit_out), 0);
        chk(line_state == 2'b00, "R1", "line_state in reset", int'(line_state), 0);
        @(negedge clk);
        rst = 1'b0;

        // warm-up preamble brings the phase into line
        put(1'b0, 4, tmp);
        put(1'b1, 4, tmp);
        put(1'b0, 4, tmp);
        put(1'b1, 4, tmp);
        put(1'b1, 12, tmp);

        // sweep one bit length over 3..6 samples
        for (int L = 3; L <= 6; L++) begin
            tag = (L == 3) ? "R5" : (L == 5) ? "R6" : (L == 6) ? "R7" : "R2";
            put(1'b0, 4, s0);
            put(1'b1, 4, s1);
            put(1'b0, 4, s2);
            put(1'b1, L, s3);
            put(1'b0, 4, s4);
            put(1'b1, 4, s5);
            put(1'b0, 4, s6);
            put(1'b1, 16, si);
            e4 = (L == 6) ? s4 + 4 : s4 + 5;
            expect_bit(s0 + 5, 1'b0, 2'b01, "R2");
            expect_bit(s1 + 5, 1'b1, 2'b10, "R2");
            expect_bit(s2 + 5, 1'b0, 2'b01, "R9");
            expect_bit(s3 + 5, 1'b1, 2'b10, "R2");
            expect_bit(e4, 1'b0, 2'b01, tag);
            expect_bit(s5 + 5, 1'b1, 2'b10, tag);
            expect_bit(s6 + 5, 1'b0, 2'b01, "R2");
            chk(count_in(s0 + 5, s6 + 5) == 7, tag, "strobes in stream window",
                count_in(s0 + 5, s6 + 5), 7);
            // R3: free-running strobes on a steady line
            expect_bit(si + 9, 1'b1, 2'b10, "R3");
            expect_bit(si + 13, 1'b1, 2'b10, "R3");
        end

        // R8: glitch right after a late transition
        put(1'b0, 5, g0);
        put(1'b1, 1, tmp);
        put(1'b0, 6, tmp);
        put(1'b1, 16, tmp);
        expect_bit(g0 + 5, 1'b0, 2'b01, "R8");
        expect_bit(g0 + 10, 1'b0, 2'b01, "R8");
        expect_none(g0 + 9, "R8");
        expect_none(g0 + 11, "R8");

        // R9: single-ended zero is reported with its own code
        put_se0(8, z0);
        put(1'b1, 16, z1);
        expect_bit(z0 + 5, 1'b0, 2'b00, "R9");
        expect_bit(z0 + 9, 1'b0, 2'b00, "R9");
        expect_bit(z1 + 5, 1'b1, 2'b10, "R9");

        chk(pulse_err == 0, "R4", "back-to-back strobe count", pulse_err, 0);
        chk(hold_err == 0, "R10", "output changes without strobe", hold_err, 0);
        chk(gap_err == 0, "R11", "strobe gaps outside 3..5", gap_err, 0);
        chk(nrec > 40, "R3", "total strobes seen above 40", nrec, 41);

        summary();
    end
endmodule